// File: doc/BRIEF.md
# Chainable Serial Configuration Register

This block holds a word of configuration bits that is loaded serially, one bit for every rising clock edge while a shift enable is high. Several chips can be strung together: the last stage of one register drives the serial input of the next chip, so a single serial line and a single clock load the whole chain.

Every configuration bit is built from two flops. A leading flop samples on the rising edge and a trailing flop copies it on the following falling edge. Each stage reads the trailing flop of the stage before it. As a result the serial output moves half a period before the next chip samples it, which gives half a clock of hold margin between chips. Loading N bits still takes exactly N rising edges. A synchronous active-low reset forces every leading and trailing flop to its own bit of a parameterised preset word. The preset is forced directly into the flops and is not shifted in. The parallel configuration word presented to the rest of the chip is taken from the leading flops.

Top module: `cfg_daisy_chain`

## Requirements
- R1: A rising edge with `rst_n` low sets `cfg_q` to `PRESET` at that edge. The following falling edge sets `ser_out` to `PRESET[CFG_W-1]`. Reset takes priority over `shift_en`.
- R2: A rising edge with `rst_n` high and `shift_en` high moves the word up one place. The new `cfg_q[0]` is `ser_in`, and the new `cfg_q[i]` is the old `cfg_q[i-1]` for i ≥ 1.
- R3: A rising edge with `rst_n` high and `shift_en` low leaves `cfg_q` unchanged, whatever `ser_in` does.
- R4: `ser_out` changes only on a falling edge. There it takes the value `cfg_q[CFG_W-1]` held at that edge, so `ser_out` never moves at a rising edge.
- R5: After a reset, CFG_W enabled rising edges load a word completely. The first bit shifted in ends in `cfg_q[CFG_W-1]` and the last bit ends in `cfg_q[0]`.
- R6: With two registers chained (`ser_out` of the upstream one to `ser_in` of the downstream one), 2·CFG_W enabled edges leave the first CFG_W bits in the downstream register and the last CFG_W bits in the upstream register, each in the order of R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; leading flops use the rising edge, trailing flops the falling edge |
| rst_n | input | 1 | Synchronous active-low reset, loads the preset word |
| shift_en | input | 1 | High: shift one place on the rising edge |
| ser_in | input | 1 | Serial data in, sampled on the rising edge |
| ser_out | output | 1 | Serial data out from the last trailing flop, changes on the falling edge |
| cfg_q | output | CFG_W | Parallel configuration word from the leading flops |

## Verification
A wrong bit in a leading flop shows on `cfg_q` in the same cycle. It then travels one place per enabled edge until it leaves on `ser_out` and reaches the downstream register's `cfg_q`. A trailing flop that is wrong or updates on the wrong edge shows one rising edge later as a wrong bit in the next stage. In the last stage it shows directly as a `ser_out` that moves at a rising edge or differs from the expected value just before one. The bench therefore compares both parallel words and both serial outputs every cycle. It also samples `ser_out` just after each rising edge to catch a change on the wrong edge.

// File: rtl/cfg_chain_pkg.sv
// Package: shared defaults and the edge selector for the configuration chain.
// Assumes nothing beyond IEEE 1800-2017 packages.
package cfg_chain_pkg;
    localparam int unsigned CFG_W_DEF = 8;
    localparam logic [CFG_W_DEF-1:0] PRESET_DEF = 8'b0110_1011;

    // Which clock edge a storage flop samples on.
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_kind_e;
endpackage

// File: rtl/cfg_edge_ff.sv
// Module: single storage flop with enable and a synchronous preset value.
// EDGE picks the sampling edge. The reset is sampled on the same edge as
// the data, so a falling-edge flop is preset on the falling edge.
// Assumes rst_n is stable around both clock edges.
module cfg_edge_ff
    import cfg_chain_pkg::*;
#(
    parameter edge_kind_e EDGE   = EDGE_RISE,
    parameter logic       PRESET = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic d,
    output logic q
);

    generate
        if (EDGE == EDGE_RISE) begin : g_rise
            // Purpose: rising-edge capture with hold when not enabled.
            always_ff @(posedge clk) begin
                if (!rst_n)  q <= PRESET;
                else if (en) q <= d;
            end

            // R3: a disabled edge keeps the stored bit.
            p_rise_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (rst_n && !en) |=> (q == $past(q)))
                else $error("p_rise_hold_r3");
        end else begin : g_fall
            // Purpose: falling-edge capture, half a period after the rising stage.
            always_ff @(negedge clk) begin
                if (!rst_n)  q <= PRESET;
                else if (en) q <= d;
            end

            // R4: the trailing copy follows its input one falling edge later.
            p_fall_copy_r4: assert property (@(negedge clk) disable iff (!rst_n)
                (rst_n && en) |=> (q == $past(d)))
                else $error("p_fall_copy_r4");
        end
    endgenerate

endmodule

// File: rtl/cfg_bit_cell.sv
// Module: one configuration bit, made of a rising-edge leading flop and a
// falling-edge trailing flop. The leading flop takes the previous stage's
// trailing output while shifting. The trailing flop always copies the
// leading flop, so it feeds the next stage with half a period of margin.
module cfg_bit_cell
    import cfg_chain_pkg::*;
#(
    parameter logic PRESET = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic ser_in,
    output logic lead_q,
    output logic trail_q
);

    // Leading flop: shift position visible on the parallel word.
    cfg_edge_ff #(.EDGE(EDGE_RISE), .PRESET(PRESET)) u_lead (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (shift_en),
        .d     (ser_in),
        .q     (lead_q)
    );

    // Trailing flop: falling-edge copy that drives the next stage.
    cfg_edge_ff #(.EDGE(EDGE_FALL), .PRESET(PRESET)) u_trail (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (1'b1),
        .d     (lead_q),
        .q     (trail_q)
    );

endmodule

// File: rtl/cfg_daisy_chain.sv
// Module: chainable serial configuration register of CFG_W bits.
// Loads one bit per enabled rising edge. The serial output comes from the
// last trailing flop and moves on the falling edge. Synchronous active-low
// reset forces PRESET into every flop.
// Assumes CFG_W >= 2.
module cfg_daisy_chain
    import cfg_chain_pkg::*;
#(
    parameter int unsigned          CFG_W  = CFG_W_DEF,
    parameter logic [CFG_W-1:0]     PRESET = PRESET_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             ser_in,
    output logic             ser_out,
    output logic [CFG_W-1:0] cfg_q
);

    localparam int unsigned LAST = CFG_W - 1;

    logic [CFG_W-1:0] stage_in;
    logic [CFG_W-1:0] lead_bits;
    logic [CFG_W-1:0] trail_bits;

    // Purpose: serial input feeds stage 0, each later stage reads its predecessor's trailing flop.
    always_comb begin
        stage_in    = {trail_bits[LAST-1:0], 1'b0};
        stage_in[0] = ser_in;
    end

    genvar gi;
    generate
        for (gi = 0; gi < CFG_W; gi++) begin : g_cell
            cfg_bit_cell #(.PRESET(PRESET[gi])) u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .shift_en (shift_en),
                .ser_in   (stage_in[gi]),
                .lead_q   (lead_bits[gi]),
                .trail_q  (trail_bits[gi])
            );
        end
    endgenerate

    assign cfg_q   = lead_bits;
    assign ser_out = trail_bits[LAST];

    // R1: a reset edge loads the preset word.
    p_reset_load_r1: assert property (@(posedge clk)
        (rst_n === 1'b0) |=> (cfg_q == PRESET))
        else $error("p_reset_load_r1");

    // R2: an enabled edge moves the word up one place and takes ser_in.
    p_shift_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && shift_en) |=> (cfg_q == {$past(cfg_q[LAST-1:0]), $past(ser_in)}))
        else $error("p_shift_step_r2");

    // R3: a disabled edge keeps the whole word.
    p_hold_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !shift_en) |=> $stable(cfg_q))
        else $error("p_hold_word_r3");

    // R4: the serial output presents the top bit as held at the previous falling edge.
    p_out_fall_r4: assert property (@(negedge clk) disable iff (!rst_n)
        rst_n |=> (ser_out == $past(cfg_q[LAST])))
        else $error("p_out_fall_r4");

endmodule

// File: tb/cfg_daisy_chain_tb_top.sv
// Bench: two chained registers against a queue model updated every cycle.
module cfg_daisy_chain_tb_top;
    import cfg_chain_pkg::*;

    localparam int unsigned W = CFG_W_DEF;
    localparam logic [W-1:0] PRE = PRESET_DEF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic shift_en = 1'b0;
    logic ser_in = 1'b0;
    logic link, sdo_dn;
    logic [W-1:0] cfg_up, cfg_dn;

    int total = 0;
    int bad = 0;
    bit model_ok = 0;
    bit model_q[$];   // index 0 = newest bit; 0..W-1 upstream, W..2W-1 downstream

    always #4 clk = ~clk;   // 125 MHz

    cfg_daisy_chain #(.CFG_W(W), .PRESET(PRE)) dut_i (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .ser_in(ser_in),
        .ser_out(link), .cfg_q(cfg_up));

    cfg_daisy_chain #(.CFG_W(W), .PRESET(PRE)) dut2_i (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .ser_in(link),
        .ser_out(sdo_dn), .cfg_q(cfg_dn));

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_word(int base);
        logic [W-1:0] w;
        for (int i = 0; i < W; i++) w[i] = model_q[base + i];
        return w;
    endfunction

    // One clock: drive after falling edge, compare before rising edge,
    // confirm ser_out still after rising edge, then advance the model.
    task automatic step(logic rn, logic en, logic din, string req);
        logic up_before, dn_before;
        @(negedge clk);
        #1;
        rst_n = rn; shift_en = en; ser_in = din;
        #2;
        if (model_ok) begin
            check({req, " cfg_up"}, 32'(cfg_up), 32'(exp_word(0)));
            check({req, " cfg_dn"}, 32'(cfg_dn), 32'(exp_word(W)));
            check("R4 ser_out up", 32'(link), 32'(model_q[W-1]));
            check("R4 ser_out dn", 32'(sdo_dn), 32'(model_q[2*W-1]));
        end
        up_before = link;
        dn_before = sdo_dn;
        @(posedge clk);
        #1;
        if (model_ok) begin
            check("R4 no move at rise up", 32'(link), 32'(up_before));
            check("R4 no move at rise dn", 32'(sdo_dn), 32'(dn_before));
        end
        if (!rn) begin
            model_q.delete();
            for (int i = 0; i < 2 * W; i++) model_q.push_back(PRE[i % W]);
            model_ok = 1;
        end else if (en) begin
            model_q.push_front(din);
            void'(model_q.pop_back());
        end
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_up();
    end

    initial begin : stim
        logic [W-1:0] pat_a, pat_b;
        pat_a = 8'b1100_1010;
        pat_b = 8'b0011_0110;
        // R1: reset, with shift_en high and noisy input (reset wins)
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, i[0], "R1 reset");
        step(1'b1, 1'b0, 1'b1, "R1 after reset");
        check("R1 preset up", 32'(cfg_up), 32'(PRE));
        check("R1 ser_out preset", 32'(sdo_dn), 32'(PRE[W-1]));
        // R5: load one word, first bit goes to the top
        for (int i = W - 1; i >= 0; i--) step(1'b1, 1'b1, pat_a[i], "R2 shift");
        step(1'b1, 1'b0, 1'b0, "R3 hold");
        check("R5 word loaded", 32'(cfg_up), 32'(pat_a));
        // R3: toggling input while disabled
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, i[0], "R3 hold");
        check("R3 word kept", 32'(cfg_up), 32'(pat_a));
        // R6: 2W bits through the chain
        step(1'b0, 1'b0, 1'b0, "R1 reset");
        for (int i = W - 1; i >= 0; i--) step(1'b1, 1'b1, pat_b[i], "R6 chain");
        for (int i = W - 1; i >= 0; i--) step(1'b1, 1'b1, pat_a[i], "R6 chain");
        step(1'b1, 1'b0, 1'b0, "R6 settle");
        check("R6 downstream", 32'(cfg_dn), 32'(pat_b));
        check("R6 upstream", 32'(cfg_up), 32'(pat_a));
        // R2/R3: mixed enables with a pseudo-random stream
        for (int i = 0; i < 200; i++)
            step(1'b1, ((i * 7) % 5) != 0, ((i * 13) % 3) == 1, "R2 mixed");
        // R1: reset in the middle of shifting
        step(1'b0, 1'b1, 1'b1, "R1 mid reset");
        step(1'b1, 1'b0, 1'b0, "R1 mid reset");
        check("R1 mid reset dn", 32'(cfg_dn), 32'(PRE));
        finish_up();
    end

endmodule